// File: doc/BRIEF.md
# Serial Instruction Decoder and Register/RAM Transfer Controller

This block sits behind the bit shifter of a serial port on a multichannel converter and handles the byte-level side of each communication cycle. A cycle opens when the cycle-active input rises. The first byte strobed in is an instruction. That byte carries four things: the transfer direction, a byte count, a byte order for RAM bursts, and a target address. The target is either one of three configuration registers or one of four coefficient/result RAMs. The bytes strobed after the instruction form the data phase. Each one is either taken from `rx_byte` (write) or presented on `tx_byte` ahead of its strobe (read).

Register writes are collected in a lane buffer and committed to the register-file port in a single masked write after the last byte. RAM writes are committed one 3-byte entry at a time. The converter must stay quiet during any RAM access, so `conv_halt` is held for the whole RAM data phase. When the RAM data phase ends, a one-cycle `conv_restart` pulse tells the sequencer to resume at logical channel 1. The sequencer uses `conv_halt` to stop scanning, clear its modulator and filter state and drop its end-of-scan interrupt.

Top module: `sercfg_ctl`

## Requirements
- R1: Instruction bit 7 selects the direction of the data phase: 1 is a write, 0 is a read. `tx_valid` is high only during a read data phase, and a read never drives `reg_wr_en` or `ram_wr_en`.
- R2: When instruction bits 3:2 are not 11, they select a register: 00 is the 2-byte control register, 01 is the first 4-byte channel-setup register and 10 is the second. Bits 1:0 give the start byte. Byte k of the data phase maps to byte index start+k of that register (byte i occupies bits 8i+7:8i).
- R3: Instruction bits 6:5 give the register byte count: values 0 to 3 mean 1 to 4 bytes. A transfer that would run past the register's last byte stops there. A start byte beyond the register moves no bytes. Bytes past the end are ignored, and the write mask never covers a byte outside the register.
- R4: When bits 3:2 are 11 the access targets a RAM selected by bits 1:0: 00 results (read-only), 01 offset, 10 positive full scale, 11 negative full scale. A RAM burst always moves 8 entries of 3 bytes (24 bytes), starting at entry 0, whatever bits 6:5 hold.
- R5: Instruction bit 4 sets the RAM byte order: 1 sends bits 23:16 of each entry first, 0 sends bits 7:0 first. The bit has no effect on register transfers.
- R6: A write instruction aimed at the results RAM pulses `ro_viol` for exactly one cycle and changes no RAM entry. It does not halt conversion.
- R7: During a RAM data phase `conv_halt` is high and the register-file port is never written.
- R8: When a RAM data phase ends, by its last byte or by abort, `conv_restart` pulses for exactly one cycle and `conv_halt` falls.
- R9: Dropping `cyc_active` mid data phase aborts the cycle. The controller then waits for a new instruction byte. A register word, or a RAM entry, whose bytes have not all arrived is not written.
- R10: After reset no transfer is active and all strobe and request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_active | input | 1 | High for the length of a communication cycle |
| byte_stb | input | 1 | One byte slot passes on this cycle |
| rx_byte | input | 8 | Incoming byte, valid with `byte_stb` |
| tx_byte | output | 8 | Outgoing byte for the current read slot |
| tx_valid | output | 1 | A read data phase has bytes remaining |
| reg_sel | output | 2 | Register addressed by the instruction |
| reg_rdata | input | 32 | Contents of the addressed register |
| reg_wr_en | output | 1 | Masked register write strobe |
| reg_wdata | output | 32 | Register write data |
| reg_wmask | output | 4 | Byte enables for the register write |
| ram_sel | output | 2 | RAM addressed by the instruction |
| ram_ridx | output | 3 | Entry currently being read |
| ram_rdata | input | 24 | Entry contents at `ram_sel`/`ram_ridx` |
| ram_wr_en | output | 1 | RAM entry write strobe |
| ram_widx | output | 3 | Entry being written |
| ram_wdata | output | 24 | Entry write data |
| conv_halt | output | 1 | Stop and clear conversion (RAM phase active) |
| conv_restart | output | 1 | One-cycle request to restart at channel 1 |
| ro_viol | output | 1 | One-cycle flag: write to the read-only RAM |

## Verification
On every cycle, the assertions enforce these rules:
- the restart and read-only flags last one cycle, and a restart only follows a halt;
- the register port is never written while conversion is halted;
- the results RAM is never written;
- a control-register mask never spills past byte 1;
- an abort clears the data phase on the next cycle.

Only the bench scenarios can show that the data itself is right:
- the right bytes reach the right register lanes for every start/count combination;
- RAM entries are assembled and returned in the selected byte order;
- the ignored bits really change nothing;
- an aborted transfer leaves a half-built word uncommitted.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

   typedef enum logic [1:0] {
      ST_INS  = 2'd0,
      ST_DATA = 2'd1,
      ST_DONE = 2'd2
   } st_e;

   typedef struct packed {
      logic       wr;
      logic       is_ram;
      logic       msb_first;
      logic [1:0] sel;
      logic [1:0] start;
      logic [2:0] nbytes;
   } ins_t;

   localparam logic [1:0] RO_BANK = 2'b00;

   function automatic ins_t decode_ins(input logic [7:0] b);
      ins_t r;
      r.wr        = b[7];
      r.nbytes    = {1'b0, b[6:5]} + 3'd1;
      r.msb_first = b[4];
      r.is_ram    = (b[3:2] == 2'b11);
      r.sel       = r.is_ram ? b[1:0] : b[3:2];
      r.start     = b[1:0];
      return r;
   endfunction

endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode
   import sercfg_pkg::*;
#(
   parameter int CR_BYTES  = 2,
   parameter int CCR_BYTES = 4,
   parameter int RAM_LEN   = 24,
   parameter int CNT_W     = 5
) (
   input  ins_t             ins,
   output logic [CNT_W-1:0] len,
   output logic             ro_bad
);

   always_comb begin
      int w;
      int avail;
      w      = (ins.sel == 2'b00) ? CR_BYTES : CCR_BYTES;
      avail  = w - int'(ins.start);
      ro_bad = ins.is_ram && ins.wr && (ins.sel == RO_BANK);
      if (ins.is_ram)
         len = CNT_W'(RAM_LEN);
      else if (avail <= 0)
         len = '0;
      else if (int'(ins.nbytes) < avail)
         len = CNT_W'(ins.nbytes);
      else
         len = CNT_W'(avail);
   end

endmodule

// File: rtl/sercfg_wbuf.sv
module sercfg_wbuf #(
   parameter int LANES = 4,
   parameter int DW    = 8,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                we,
   input  logic [LW-1:0]       lane,
   input  logic [DW-1:0]       din,
   output logic [LANES*DW-1:0] merged,
   output logic [LANES-1:0]    mask_n
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [DW-1:0] q;
      logic          m;
      logic          hit;
      assign hit = we && (lane == LW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
            m <= 1'b0;
         end else if (clr) begin
            m <= 1'b0;
         end else if (hit) begin
            q <= din;
            m <= 1'b1;
         end
      end
      assign merged[i*DW +: DW] = hit ? din : q;
      assign mask_n[i]          = m | hit;
   end

endmodule

// File: rtl/sercfg_ctl.sv
module sercfg_ctl
   import sercfg_pkg::*;
#(
   parameter int DW          = 8,
   parameter int CR_BYTES    = 2,
   parameter int CCR_BYTES   = 4,
   parameter int RAM_ENTRIES = 8,
   parameter int ENTRY_BYTES = 3,
   localparam int REG_W      = CCR_BYTES * DW,
   localparam int ENT_W      = ENTRY_BYTES * DW,
   localparam int IDX_W      = $clog2(RAM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_active,
   input  logic             byte_stb,
   input  logic [DW-1:0]    rx_byte,
   output logic [DW-1:0]    tx_byte,
   output logic             tx_valid,
   output logic [1:0]       reg_sel,
   input  logic [REG_W-1:0] reg_rdata,
   output logic             reg_wr_en,
   output logic [REG_W-1:0] reg_wdata,
   output logic [CCR_BYTES-1:0] reg_wmask,
   output logic [1:0]       ram_sel,
   output logic [IDX_W-1:0] ram_ridx,
   input  logic [ENT_W-1:0] ram_rdata,
   output logic             ram_wr_en,
   output logic [IDX_W-1:0] ram_widx,
   output logic [ENT_W-1:0] ram_wdata,
   output logic             conv_halt,
   output logic             conv_restart,
   output logic             ro_viol
);

   localparam int RAM_LEN   = RAM_ENTRIES * ENTRY_BYTES;
   localparam int CNT_W     = $clog2(RAM_LEN + 1);
   localparam int SUB_W     = $clog2(ENTRY_BYTES);
   localparam int BUF_BYTES = (CCR_BYTES > ENTRY_BYTES) ? CCR_BYTES : ENTRY_BYTES;
   localparam int BUF_W     = BUF_BYTES * DW;
   localparam int LANE_W    = $clog2(BUF_BYTES);

   if (DW != 8) begin : g_bad_dw
      $error("sercfg_ctl: instruction layout needs 8-bit bytes");
   end
   if (CCR_BYTES > 4 || CR_BYTES > CCR_BYTES || CR_BYTES < 1) begin : g_bad_reg
      $error("sercfg_ctl: register widths must satisfy 1 <= CR <= CCR <= 4");
   end
   if (ENTRY_BYTES < 2 || RAM_ENTRIES < 2) begin : g_bad_ram
      $error("sercfg_ctl: RAM needs at least 2 entries of at least 2 bytes");
   end

   st_e              st;
   ins_t             ins_q, ins_d;
   logic [CNT_W-1:0] cnt, len_q, len_d;
   logic [IDX_W-1:0] ent;
   logic [SUB_W-1:0] sub;
   logic             ro_d;

   assign ins_d = decode_ins(rx_byte);

   sercfg_decode #(
      .CR_BYTES (CR_BYTES),
      .CCR_BYTES(CCR_BYTES),
      .RAM_LEN  (RAM_LEN),
      .CNT_W    (CNT_W)
   ) u_dec (
      .ins   (ins_d),
      .len   (len_d),
      .ro_bad(ro_d)
   );

   logic              data_stb, last, entry_end, we_buf;
   logic              commit_reg, commit_ram, clr_buf;
   logic [LANE_W-1:0] lane;
   logic [BUF_W-1:0]  merged, word;
   logic [BUF_BYTES-1:0] mask_n;

   assign data_stb  = byte_stb && cyc_active && (st == ST_DATA);
   assign last      = (cnt == len_q - CNT_W'(1));
   assign entry_end = (sub == SUB_W'(ENTRY_BYTES - 1));
   assign we_buf    = data_stb && ins_q.wr;
   assign commit_reg = we_buf && !ins_q.is_ram && last;
   assign commit_ram = we_buf && ins_q.is_ram && entry_end;
   assign clr_buf   = commit_reg || commit_ram || (st != ST_DATA);

   always_comb begin
      if (ins_q.is_ram)
         lane = ins_q.msb_first ? LANE_W'(ENTRY_BYTES - 1 - int'(sub)) : LANE_W'(sub);
      else
         lane = LANE_W'(int'(ins_q.start) + int'(cnt));
   end

   sercfg_wbuf #(.LANES(BUF_BYTES), .DW(DW)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_buf),
      .we    (we_buf),
      .lane  (lane),
      .din   (rx_byte),
      .merged(merged),
      .mask_n(mask_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_INS;
         ins_q        <= '0;
         len_q        <= '0;
         cnt          <= '0;
         ent          <= '0;
         sub          <= '0;
         conv_restart <= 1'b0;
         ro_viol      <= 1'b0;
         reg_wr_en    <= 1'b0;
         reg_wdata    <= '0;
         reg_wmask    <= '0;
         ram_wr_en    <= 1'b0;
         ram_widx     <= '0;
         ram_wdata    <= '0;
      end else begin
         conv_restart <= 1'b0;
         ro_viol      <= 1'b0;
         reg_wr_en    <= 1'b0;
         ram_wr_en    <= 1'b0;
         if (!cyc_active) begin
            if (st == ST_DATA && ins_q.is_ram) conv_restart <= 1'b1;
            st <= ST_INS;
         end else begin
            case (st)
               ST_INS: if (byte_stb) begin
                  ins_q <= ins_d;
                  len_q <= len_d;
                  cnt   <= '0;
                  ent   <= '0;
                  sub   <= '0;
                  if (ro_d) begin
                     ro_viol <= 1'b1;
                     st      <= ST_DONE;
                  end else if (len_d == '0) begin
                     st <= ST_DONE;
                  end else begin
                     st <= ST_DATA;
                  end
               end
               ST_DATA: if (byte_stb) begin
                  cnt <= cnt + CNT_W'(1);
                  if (entry_end) begin
                     sub <= '0;
                     ent <= ent + IDX_W'(1);
                  end else begin
                     sub <= sub + SUB_W'(1);
                  end
                  if (commit_reg) begin
                     reg_wr_en <= 1'b1;
                     reg_wdata <= merged[REG_W-1:0];
                     reg_wmask <= mask_n[CCR_BYTES-1:0];
                  end
                  if (commit_ram) begin
                     ram_wr_en <= 1'b1;
                     ram_widx  <= ent;
                     ram_wdata <= merged[ENT_W-1:0];
                  end
                  if (last) begin
                     st <= ST_DONE;
                     if (ins_q.is_ram) conv_restart <= 1'b1;
                  end
               end
               default: st <= st;
            endcase
         end
      end
   end

   assign reg_sel   = ins_q.sel;
   assign ram_sel   = ins_q.sel;
   assign ram_ridx  = ent;
   assign conv_halt = (st == ST_DATA) && ins_q.is_ram;
   assign tx_valid  = (st == ST_DATA) && !ins_q.wr;
   assign word      = ins_q.is_ram ? BUF_W'(ram_rdata) : BUF_W'(reg_rdata);
   assign tx_byte   = tx_valid ? word[int'(lane)*DW +: DW] : '0;

endmodule

// File: rtl/sercfg_ctl_chk.sv
module sercfg_ctl_chk #(
   parameter int CR_BYTES  = 2,
   parameter int CCR_BYTES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cyc_active,
   input logic                 tx_valid,
   input logic [1:0]           reg_sel,
   input logic                 reg_wr_en,
   input logic [CCR_BYTES-1:0] reg_wmask,
   input logic [1:0]           ram_sel,
   input logic                 ram_wr_en,
   input logic                 conv_halt,
   input logic                 conv_restart,
   input logic                 ro_viol
);

   AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_restart |=> !conv_restart); // R8
   AST_RESTART_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      conv_restart |-> ($past(conv_halt) && !conv_halt)); // R8
   AST_NO_REG_WRITE_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      conv_halt |-> !reg_wr_en); // R7
   AST_RO_BANK_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_en |-> (ram_sel != 2'b00)); // R6
   AST_RO_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ro_viol |=> !ro_viol); // R6
   AST_RO_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      ro_viol |-> !conv_halt); // R6
   AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !ram_wr_en); // R1
   AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (reg_wmask != '0)); // R3
   AST_CR_MASK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_sel == 2'b00) |-> ((reg_wmask >> CR_BYTES) == '0)); // R3
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_active |=> (!tx_valid && !conv_halt)); // R9

endmodule

bind sercfg_ctl sercfg_ctl_chk #(.CR_BYTES(CR_BYTES), .CCR_BYTES(CCR_BYTES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_active  (cyc_active),
   .tx_valid    (tx_valid),
   .reg_sel     (reg_sel),
   .reg_wr_en   (reg_wr_en),
   .reg_wmask   (reg_wmask),
   .ram_sel     (ram_sel),
   .ram_wr_en   (ram_wr_en),
   .conv_halt   (conv_halt),
   .conv_restart(conv_restart),
   .ro_viol     (ro_viol)
);

// File: tb/tb_sercfg_ctl.sv
module tb_sercfg_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc = 1'b0;
   logic        stb = 1'b0;
   logic [7:0]  rx = '0;
   logic [7:0]  tx_byte;
   logic        tx_valid;
   logic [1:0]  reg_sel;
   logic [31:0] reg_rdata;
   logic        reg_wr_en;
   logic [31:0] reg_wdata;
   logic [3:0]  reg_wmask;
   logic [1:0]  ram_sel;
   logic [2:0]  ram_ridx;
   logic [23:0] ram_rdata;
   logic        ram_wr_en;
   logic [2:0]  ram_widx;
   logic [23:0] ram_wdata;
   logic        conv_halt, conv_restart, ro_viol;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sercfg_ctl dut (
      .clk(clk), .rst_n(rst_n), .cyc_active(cyc), .byte_stb(stb), .rx_byte(rx),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
      .ram_sel(ram_sel), .ram_ridx(ram_ridx), .ram_rdata(ram_rdata),
      .ram_wr_en(ram_wr_en), .ram_widx(ram_widx), .ram_wdata(ram_wdata),
      .conv_halt(conv_halt), .conv_restart(conv_restart), .ro_viol(ro_viol)
   );

   // storage models driven only by the block's ports
   logic [31:0] rf [3];
   logic [23:0] ram_m [4][8];
   logic [31:0] sh [3];
   logic [23:0] shram [4][8];

   assign reg_rdata = (reg_sel == 2'd3) ? 32'h0 : rf[reg_sel];
   assign ram_rdata = ram_m[ram_sel][ram_ridx];

   always @(posedge clk) begin
      if (reg_wr_en && reg_sel != 2'd3)
         for (int i = 0; i < 4; i++)
            if (reg_wmask[i]) rf[reg_sel][8*i +: 8] <= reg_wdata[8*i +: 8];
      if (ram_wr_en) ram_m[ram_sel][ram_widx] <= ram_wdata;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      stb = 1'b1;
      rx  = b;
      @(negedge clk);
      stb = 1'b0;
   endtask

   task automatic open_cyc();
      @(negedge clk);
      cyc = 1'b1;
   endtask

   task automatic close_cyc();
      @(negedge clk);
      cyc = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [7:0] ramb(int s, int o, int k);
      return 8'((k * 7 + s * 40 + o * 3 + 1) & 255);
   endfunction

   function automatic int reg_len(int sel, int start, int nb);
      int w;
      w = (sel == 0) ? 2 : 4;
      if (start >= w) return 0;
      return ((nb + 1) < (w - start)) ? nb + 1 : w - start;
   endfunction

   // read a full RAM burst in order o and compare with shadow
   task automatic ram_read(input int s, input int o, input logic [1:0] junk_nb);
      open_cyc();
      send({1'b0, junk_nb, 1'(o), 2'b11, 2'(s)});
      for (int k = 0; k < 24; k++) begin
         int e, j, ln;
         e  = k / 3;
         j  = k % 3;
         ln = (o != 0) ? 2 - j : j;
         chk($sformatf("R4/R5 ram%0d ord%0d byte%0d", s, o, k), {24'h0, tx_byte},
             {24'h0, shram[s][e][8*ln +: 8]});
         if (k == 5) chk("R7 halt during RAM read", {31'h0, conv_halt}, 32'h1);
         send(8'hA5);
      end
      chk("R8 restart pulse at burst end", {30'h0, conv_restart, conv_halt}, 32'h2);
      @(negedge clk);
      chk("R8 restart single cycle", {31'h0, conv_restart}, 32'h0);
      close_cyc();
   endtask

   task automatic ram_write(input int s, input int o);
      open_cyc();
      send({1'b1, 2'b10, 1'(o), 2'b11, 2'(s)});
      for (int k = 0; k < 24; k++) begin
         int e, j, ln;
         e  = k / 3;
         j  = k % 3;
         ln = (o != 0) ? 2 - j : j;
         shram[s][e][8*ln +: 8] = ramb(s, o, k);
         send(ramb(s, o, k));
      end
      chk("R8 restart after RAM write", {31'h0, conv_restart}, 32'h1);
      close_cyc();
      for (int e = 0; e < 8; e++)
         chk($sformatf("R4 ram%0d entry%0d stored", s, e), {8'h0, ram_m[s][e]}, {8'h0, shram[s][e]});
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin rf[i] = '0; sh[i] = '0; end
      for (int s = 0; s < 4; s++)
         for (int e = 0; e < 8; e++) begin
            ram_m[s][e] = (s == 0) ? 24'(e * 24'h010203 + 24'h0A0B0C) : 24'h0;
            shram[s][e] = ram_m[s][e];
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 reset outputs", {25'h0, tx_valid, conv_halt, conv_restart, ro_viol,
          reg_wr_en, ram_wr_en, 1'b0}, 32'h0);

      // R2/R3/R5: sweep every register, start byte and count, write then read
      for (int sel = 0; sel < 3; sel++)
         for (int start = 0; start < 4; start++)
            for (int nb = 0; nb < 4; nb++) begin
               int len;
               logic rb;
               len = reg_len(sel, start, nb);
               rb  = 1'((start + nb) % 2);   // R5: ignored for registers
               open_cyc();
               send({1'b1, 2'(nb), rb, 2'(sel), 2'(start)});
               for (int k = 0; k <= nb; k++) begin
                  logic [7:0] d;
                  d = 8'(sel * 64 + start * 16 + nb * 4 + k + 1);
                  chk("R1 no tx during write", {31'h0, tx_valid}, 32'h0);
                  if (k < len) sh[sel][8*(start+k) +: 8] = d;
                  send(d);
               end
               close_cyc();
               for (int r = 0; r < 3; r++)
                  chk($sformatf("R2/R3 reg%0d after write s%0d n%0d", r, start, nb), rf[r], sh[r]);
               open_cyc();
               send({1'b0, 2'(nb), ~rb, 2'(sel), 2'(start)});
               for (int k = 0; k <= nb; k++) begin
                  if (k < len)
                     chk($sformatf("R2 read reg%0d byte%0d", sel, start + k),
                         {23'h0, tx_valid, tx_byte}, {23'h0, 1'b1, sh[sel][8*(start+k) +: 8]});
                  else
                     chk("R3 read past end idle", {31'h0, tx_valid}, 32'h0);
                  send(8'h5A);
               end
               close_cyc();
            end

      // R4/R5: burst writes to the writable RAMs, read back in both orders
      for (int s = 1; s < 4; s++) begin
         ram_write(s, s % 2);
         ram_read(s, 0, 2'b00);
         ram_read(s, 1, 2'b11);
      end
      ram_read(0, 0, 2'b01);
      ram_read(0, 1, 2'b10);
      for (int r = 0; r < 3; r++)
         chk("R7 registers unchanged by RAM access", rf[r], sh[r]);

      // R6: write to the read-only results RAM
      open_cyc();
      send({1'b1, 2'b00, 1'b1, 2'b11, 2'b00});
      chk("R6 ro_viol pulse, no halt", {30'h0, ro_viol, conv_halt}, 32'h2);
      for (int k = 0; k < 6; k++) begin
         send(8'hEE);
         if (k == 0) chk("R6 ro_viol one cycle", {31'h0, ro_viol}, 32'h0);
      end
      close_cyc();
      for (int e = 0; e < 8; e++)
         chk("R6 results RAM unchanged", {8'h0, ram_m[0][e]}, {8'h0, shram[0][e]});

      // R9: abort a register write after 2 of 4 bytes
      open_cyc();
      send({1'b1, 2'b11, 1'b0, 2'b10, 2'b00});
      send(8'h11);
      send(8'h22);
      @(negedge clk);
      cyc = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 aborted register write not committed", rf[2], sh[2]);
      open_cyc();
      send({1'b0, 2'b00, 1'b0, 2'b10, 2'b00});
      chk("R9 new instruction accepted after abort", {23'h0, tx_valid, tx_byte},
          {23'h0, 1'b1, sh[2][7:0]});
      close_cyc();

      // R9/R8: abort a RAM write inside entry 1
      open_cyc();
      send({1'b1, 2'b00, 1'b0, 2'b11, 2'b01});
      for (int k = 0; k < 4; k++) send(8'(8'hC0 + k));
      shram[1][0] = {8'hC2, 8'hC1, 8'hC0};
      @(negedge clk);
      cyc = 1'b0;
      @(negedge clk);
      chk("R8 restart on RAM abort", {30'h0, conv_restart, conv_halt}, 32'h2);
      @(negedge clk);
      chk("R8 restart on abort single cycle", {31'h0, conv_restart}, 32'h0);
      repeat (2) @(negedge clk);
      chk("R9 complete entry committed", {8'h0, ram_m[1][0]}, {8'h0, shram[1][0]});
      chk("R9 partial entry discarded", {8'h0, ram_m[1][1]}, {8'h0, shram[1][1]});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule